// File: doc/BRIEF.md
# Read Data Alignment Pipeline with Selectable CAS Latency

This block sits on the controller side of a synchronous DRAM interface. For every read-column command that the controller puts on the command bus, it predicts the bus cycles on which the memory will drive read data. On exactly those cycles it raises a capture strobe together with the index of the beat within its burst. The capture logic can then register the data bus with no further knowledge of the command stream.

The distance from command to data is selected at run time as two or three clocks. Each read opens a burst of 1, 2, 4 or 8 beats, and a later read may cut that burst short at any clock. A halt (a burst stop or a precharge on the command bus) ends the burst in progress. Beats issued before the halt still arrive, and no beats follow it. A read mask sampled with the command bus removes the beat two clocks later, whatever the latency. Changing the latency while read beats are outstanding is illegal, and the block reports it with a one-cycle error pulse.

Top module: `rdp_read_align`

## Requirements
- R1: While `rst_n` is low at a rising edge, the outputs after that edge are `cap_vld`=0, `cap_beat`=0 and `lat_err`=0.
- R2: With `cas_lat3`=0 (latency 2), a read sampled at edge t gives `cap_vld`=1 and `cap_beat`=0 after edge t+2, provided no mask suppresses that beat.
- R3: With `cas_lat3`=1 (latency 3), a read sampled at edge t gives `cap_vld`=1 and `cap_beat`=0 after edge t+3, provided no mask suppresses that beat.
- R4: `blen_sel` is sampled with the read and selects 2^`blen_sel` beats (0:1, 1:2, 2:4, 3:8). The beats arrive on consecutive cycles with indices 0, 1, 2 and so on, and the strobe then drops.
- R5: A read sampled while a burst is still issuing replaces that burst from the same clock. Its beat 0 follows the previous beat with no gap, including reads on every clock.
- R6: `rd_halt` sampled at edge s with no read ends the current burst, so no beat is issued for edge s or later. A read and a halt at the same edge act as a read alone.
- R7: `dqm` sampled at edge m forces `cap_vld`=0 after edge m+2 at either latency. The following beats keep their indices.
- R8: `lat_err` is 1 for one cycle after an edge at which `cas_lat3` differs from its value at the previous edge while a read is in flight. In flight means the burst still has beats to issue, or a beat was issued at one of the three preceding edges. Otherwise `lat_err` is 0.
- R9: `cap_beat` is 0 whenever `cap_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cas_lat3 | input | 1 | Latency select: 1 gives three clocks, 0 gives two |
| blen_sel | input | 2 | Burst length code, sampled with each read |
| rd_cmd | input | 1 | One-cycle pulse per read-column command |
| rd_halt | input | 1 | Burst stop or precharge seen on the command bus |
| dqm | input | 1 | Read mask for the beat due two clocks later |
| cap_vld | output | 1 | Data bus carries a valid read beat this cycle |
| cap_beat | output | 3 | Index of that beat within its burst |
| lat_err | output | 1 | Latency changed while reads were outstanding |

## Verification
The latency properties take `cas_lat3` at the delivery edge as the latency in force, because the block picks its tap with the current setting. A legal command stream therefore holds the setting steady from the read until its last beat. The directed phases keep to that rule except in the one phase that breaks it on purpose to raise `lat_err`. The random phase changes the latency rarely, sometimes in the middle of a burst. There the comparison uses the same tap-follows-current-setting behaviour, so the illegal changes are checked as well. Reads, halts and masks are drawn independently, so a read together with a halt and a mask on a beat that was already cut off both occur.

// File: rtl/rdp_pkg.sv
// Shared constants and the beat slot type for the read alignment pipeline.
// Assumes burst lengths are powers of two up to 2**BEAT_W beats.
package rdp_pkg;
    localparam int unsigned BEAT_W     = 3;
    localparam int unsigned BLEN_SEL_W = $clog2(BEAT_W + 1);
    localparam int unsigned LAT_SHORT  = 2;
    localparam int unsigned LAT_LONG   = 3;
    localparam int unsigned MAX_LAT    = LAT_LONG;
    localparam int unsigned MASK_DLY   = 2;
    localparam int unsigned REM_W      = BEAT_W + 1;

    typedef struct packed {
        logic              vld;
        logic [BEAT_W-1:0] idx;
    } beat_slot_t;
endpackage

// File: rtl/rdp_burst_gen.sv
// Burst generator: turns read and halt commands into one beat slot per
// clock, in command time. A read restarts the burst; a halt ends it.
// Assumes rd_cmd takes priority over rd_halt in the same cycle.
module rdp_burst_gen
    import rdp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_cmd,
    input  logic                  rd_halt,
    input  logic [BLEN_SEL_W-1:0] blen_sel,
    output beat_slot_t            slot,
    output logic                  active
);
    logic [REM_W-1:0]  rem_q, rem_d;
    logic [BEAT_W-1:0] nidx_q, nidx_d;

    // Next-slot and next-counter selection for this clock.
    always_comb begin
        slot   = '0;
        rem_d  = rem_q;
        nidx_d = nidx_q;
        if (rd_cmd) begin
            slot.vld = 1'b1;
            slot.idx = '0;
            rem_d    = (REM_W'(1) << blen_sel) - REM_W'(1);
            nidx_d   = BEAT_W'(1);
        end else if (rd_halt) begin
            rem_d = '0;
        end else if (rem_q != '0) begin
            slot.vld = 1'b1;
            slot.idx = nidx_q;
            rem_d    = rem_q - REM_W'(1);
            nidx_d   = nidx_q + BEAT_W'(1);
        end
    end

    // Remaining-beat and next-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            nidx_q <= '0;
        end else begin
            rem_q  <= rem_d;
            nidx_q <= nidx_d;
        end
    end

    assign active = (rem_q != '0);
endmodule

// File: rtl/rdp_delay_line.sv
// Delay line: shifts beat slots through MAX_LAT stages and taps the stage
// chosen by the latency select. It applies the read mask MASK_DLY clocks
// after sampling, independent of latency. Assumes the latency is steady
// while slots are in the line.
module rdp_delay_line
    import rdp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  beat_slot_t slot_in,
    input  logic       lat3,
    input  logic       mask,
    output beat_slot_t slot_out,
    output logic       busy
);
    beat_slot_t          stg [MAX_LAT];
    logic [MASK_DLY-1:0] mq;
    beat_slot_t          tap;

    // Slot shift register, one stage per clock of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MAX_LAT; k++) stg[k] <= '0;
        end else begin
            stg[0] <= slot_in;
            for (int k = 1; k < MAX_LAT; k++) stg[k] <= stg[k-1];
        end
    end

    // Mask delay chain.
    always_ff @(posedge clk) begin
        if (!rst_n) mq <= '0;
        else        mq <= {mq[MASK_DLY-2:0], mask};
    end

    // Latency tap selection.
    always_comb begin
        tap = lat3 ? stg[LAT_LONG-1] : stg[LAT_SHORT-1];
    end

    // Output register with the mask applied.
    always_ff @(posedge clk) begin
        if (!rst_n)                          slot_out <= '0;
        else if (tap.vld && !mq[MASK_DLY-1]) slot_out <= tap;
        else                                 slot_out <= '0;
    end

    // Any slot still travelling through the stages.
    always_comb begin
        busy = 1'b0;
        for (int k = 0; k < MAX_LAT; k++) busy = busy | stg[k].vld;
    end
endmodule

// File: rtl/rdp_lat_guard.sv
// Latency guard: remembers the last sampled latency select and pulses an
// error when it changes while reads are in flight. Assumes busy covers
// every beat not yet delivered.
module rdp_lat_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic lat3,
    input  logic busy,
    output logic lat_err
);
    logic lat_q;

    // Previous latency and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q   <= 1'b0;
            lat_err <= 1'b0;
        end else begin
            lat_q   <= lat3;
            lat_err <= busy && (lat3 != lat_q);
        end
    end
endmodule

// File: rtl/rdp_read_align.sv
// Top: read data alignment pipeline. It predicts the cycles that carry
// read data for a 2- or 3-clock CAS latency and strobes them with the
// beat index. Assumes rd_cmd, rd_halt and dqm are sampled from the
// command bus on the same edge the memory samples them.
module rdp_read_align
    import rdp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cas_lat3,
    input  logic [BLEN_SEL_W-1:0] blen_sel,
    input  logic                  rd_cmd,
    input  logic                  rd_halt,
    input  logic                  dqm,
    output logic                  cap_vld,
    output logic [BEAT_W-1:0]     cap_beat,
    output logic                  lat_err
);
    beat_slot_t slot_now;
    beat_slot_t slot_dly;
    logic       gen_active;
    logic       line_busy;
    logic       in_flight;

    rdp_burst_gen u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cmd   (rd_cmd),
        .rd_halt  (rd_halt),
        .blen_sel (blen_sel),
        .slot     (slot_now),
        .active   (gen_active)
    );

    rdp_delay_line u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_in  (slot_now),
        .lat3     (cas_lat3),
        .mask     (dqm),
        .slot_out (slot_dly),
        .busy     (line_busy)
    );

    // Reads outstanding anywhere in the pipeline.
    assign in_flight = gen_active | line_busy;

    rdp_lat_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .lat3    (cas_lat3),
        .busy    (in_flight),
        .lat_err (lat_err)
    );

    assign cap_vld  = slot_dly.vld;
    assign cap_beat = slot_dly.idx;
endmodule

// File: rtl/rdp_read_align_chk.sv
// Checker for rdp_read_align, bound to every instance of the top module.
// It watches only the top-level ports.
module rdp_read_align_chk
    import rdp_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cas_lat3,
    input logic [BLEN_SEL_W-1:0] blen_sel,
    input logic                  rd_cmd,
    input logic                  rd_halt,
    input logic                  dqm,
    input logic                  cap_vld,
    input logic [BEAT_W-1:0]     cap_beat,
    input logic                  lat_err
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!cap_vld && !lat_err && cap_beat == '0)); // R1

    AST_LAT2_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !dqm) ##1 1'b1 ##1 !cas_lat3 |=> (cap_vld && cap_beat == '0)); // R2

    AST_LAT3_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd ##1 !dqm ##1 1'b1 ##1 cas_lat3 |=> (cap_vld && cap_beat == '0)); // R3

    AST_HALT_DROPS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_halt && !rd_cmd) ##1 1'b1 ##1 !cas_lat3 |=> !cap_vld); // R6

    AST_MASK_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        dqm ##1 1'b1 ##1 1'b1 |=> !cap_vld); // R7

    AST_LAT_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        lat_err |-> ($past(cas_lat3) != $past(cas_lat3, 2))); // R8

    AST_IDLE_BEAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_vld |-> (cap_beat == '0)); // R9

    // blen_sel is an input of the bound top and is observed for completeness.
    logic unused_blen;
    assign unused_blen = ^blen_sel;
endmodule

bind rdp_read_align rdp_read_align_chk u_chk (.*);

// File: tb/sim_rdp_read_align.sv
// Self-checking bench for rdp_read_align: directed corner cases followed
// by seeded random traffic, compared each cycle against a model of the
// requirements.
module sim_rdp_read_align;
    import rdp_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  cas_lat3;
    logic [BLEN_SEL_W-1:0] blen_sel;
    logic                  rd_cmd;
    logic                  rd_halt;
    logic                  dqm;
    logic                  cap_vld;
    logic [BEAT_W-1:0]     cap_beat;
    logic                  lat_err;

    always #10 clk = ~clk;

    rdp_read_align u0 (.*);

    int    checks = 0;
    int    errors = 0;
    string tag = "R1";

    // Model history, indexed by edge number modulo 8.
    bit sv [8];
    int si [8];
    bit mk [8];
    int n;
    int rem;
    int nidx;
    bit lat_prev;
    bit cur_l3;
    int cur_bs;

    function automatic int blen_of(int code);
        return 1 << code;
    endfunction

    function automatic int lat_of(bit l3);
        return l3 ? 3 : 2;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", req, what, act, exp, n);
        end
    endtask

    // One clock: drive at negedge, model at posedge, compare at next negedge.
    task automatic cyc(bit rd, bit halt, bit m);
        bit busy;
        bit e_err;
        bit e_v;
        int e_i;
        int lat;
        rd_cmd   = rd;
        rd_halt  = halt;
        dqm      = m;
        cas_lat3 = cur_l3;
        blen_sel = BLEN_SEL_W'(cur_bs);
        @(posedge clk);
        n++;
        busy  = (rem > 0) || sv[(n-1)%8] || sv[(n-2)%8] || sv[(n-3)%8];
        e_err = busy && (cur_l3 != lat_prev);
        lat_prev = cur_l3;
        sv[n%8] = 1'b0;
        si[n%8] = 0;
        if (rd) begin
            sv[n%8] = 1'b1;
            si[n%8] = 0;
            rem  = blen_of(cur_bs) - 1;
            nidx = 1;
        end else if (halt) begin
            rem = 0;
        end else if (rem > 0) begin
            sv[n%8] = 1'b1;
            si[n%8] = nidx;
            nidx++;
            rem--;
        end
        mk[n%8] = m;
        lat = lat_of(cur_l3);
        e_v = sv[(n-lat)%8] && !mk[(n-2)%8];
        e_i = e_v ? si[(n-lat)%8] : 0;
        @(negedge clk);
        check(tag, "cap_vld", int'(cap_vld), int'(e_v));
        check(e_v ? tag : "R9", "cap_beat", int'(cap_beat), e_i);
        check("R8", "lat_err", int'(lat_err), int'(e_err));
    endtask

    task automatic idle(int k);
        for (int j = 0; j < k; j++) cyc(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; cas_lat3 = 1'b0; blen_sel = '0;
        rd_cmd = 1'b0; rd_halt = 1'b0; dqm = 1'b0;
        for (int j = 0; j < 8; j++) begin sv[j] = 0; si[j] = 0; mk[j] = 0; end
        n = 8; rem = 0; nidx = 0; lat_prev = 0; cur_l3 = 0; cur_bs = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "cap_vld in reset", int'(cap_vld), 0);
        check("R1", "cap_beat in reset", int'(cap_beat), 0);
        check("R1", "lat_err in reset", int'(lat_err), 0);
        rst_n = 1'b1;

        // R2: latency 2, burst of 4
        tag = "R2"; cur_l3 = 0; cur_bs = 2;
        cyc(1, 0, 0); idle(8);

        // R3: latency 3 (changed while idle), bursts of 8, 1 and 2
        tag = "R3"; cur_l3 = 1; cur_bs = 3;
        idle(2);
        cyc(1, 0, 0); idle(12);
        cur_bs = 0; cyc(1, 0, 0); idle(5);
        cur_bs = 1; cyc(1, 0, 0); idle(5);

        // R4: every burst length code at latency 2
        tag = "R4"; cur_l3 = 0; idle(2);
        for (int b = 0; b < 4; b++) begin
            cur_bs = b; cyc(1, 0, 0); idle(10);
        end

        // R5: reads on every clock, then a read in mid-burst
        tag = "R5"; cur_bs = 2;
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
        idle(2); cyc(1, 0, 0); idle(8);
        cur_l3 = 1; idle(2);
        cur_bs = 3; cyc(1, 0, 0); idle(3); cyc(1, 0, 0); idle(12);

        // R6: halt in mid-burst, halt together with a read
        tag = "R6"; cur_bs = 3;
        cyc(1, 0, 0); idle(2); cyc(0, 1, 0); idle(8);
        cur_l3 = 0; idle(2);
        cyc(1, 0, 0); idle(1); cyc(1, 1, 0); idle(10);
        cyc(0, 1, 0); idle(4);

        // R7: masks at both latencies
        tag = "R7"; cur_bs = 3;
        cyc(1, 1, 1); cyc(0, 0, 0); cyc(0, 0, 1); idle(10);
        cur_l3 = 1; idle(2);
        cyc(1, 0, 0); cyc(0, 0, 1); cyc(0, 0, 1); idle(10);

        // R8: change while idle (no error), change in flight (error)
        tag = "R8"; cur_bs = 2;
        cur_l3 = 0; idle(3);
        cyc(1, 0, 0); cur_l3 = 1; cyc(0, 0, 0); idle(10);
        cur_l3 = 0; idle(3);

        // Random traffic
        tag = "R5";
        for (int j = 0; j < 4000; j++) begin
            bit r;
            bit h;
            bit m;
            r = ($urandom % 100) < 30;
            h = ($urandom % 100) < 10;
            m = ($urandom % 100) < 15;
            if (($urandom % 100) < 2) cur_l3 = ~cur_l3;
            cur_bs = $urandom % 4;
            cyc(r, h, m);
        end
        idle(12);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired at edge %0d", n);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule